// File: doc/BRIEF.md
# Oversampled Serial Line Capture Framer

This block captures a slow serial link by sampling its data line and its clock line together at a fixed internal rate. The rate is counted in derived-clock ticks. A block-start pulse opens each capture period, and the first pair of samples is taken in that same cycle. Further pairs follow every programmed number of derived-clock enables. Each pair goes into a small capture store: data samples in the upper byte of a word, clock samples in the lower byte, oldest first.

When the next block-start pulse arrives, the finished period is copied into an emission buffer, and a new capture begins in the same cycle. The finished period leaves as a stream of 16-bit words under a valid/ready handshake. The stream is a three-word header (channel and type, valid bit count, sampling mode and period) followed by the packed sample words. The first block-start after reset only opens a capture, because there is no earlier period to send. Recovering serial bits from the samples is left to downstream logic.

Top module: `ovs_capture`

## Requirements
- R1: After reset `out_valid` is low, and no word is emitted until the second block-start pulse, because the first pulse only opens a capture.
- R2: Header word 0 carries the channel number of the emitted period in bits 15:11, the value 2 in bits 10:8, and zeros in bits 7:0.
- R3: Header word 2 has bit 15 set, bits 14:9 clear, and bits 8:0 equal to the sample period in effect during the emitted period.
- R4: A sample pair is taken in the block-start cycle when the period P is nonzero. Further pairs are taken on every P-th cycle in which `dclk_en` is high, counted from that start.
- R5: Pair n goes to data word n/8, with the data sample at bit 15-(n mod 8) and the clock sample at bit 7-(n mod 8). A full last word therefore ends with data at bit 8 and clock at bit 0.
- R6: Header word 1 equals twice the number of stored pairs. (word1+15)/16 data words follow it, and positions not filled by a sample read zero.
- R7: A sample period of 0 stores no samples, so the emitted period is three header words with a bit count of 0.
- R8: Pairs beyond the store capacity of WORDS*8 are discarded, and the bit count stays at 16*WORDS.
- R9: While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` hold. A word advances only on a cycle with both high.
- R10: Both serial lines pass through two flops, so a pair sampled at clock edge t holds the line levels present at edge t-2.
- R11: Channel and period inputs are taken only at a block-start pulse. Changing them mid-period alters neither that period's header nor its sampling schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | One-cycle pulse opening a capture period |
| dclk_en | input | 1 | Derived-clock enable, one cycle per derived tick |
| ser_data | input | 1 | Asynchronous serial data line |
| ser_clk | input | 1 | Asynchronous serial clock line |
| cfg_chan_id | input | 5 | Channel number, taken at block start |
| cfg_period | input | 9 | Sample period in derived ticks, taken at block start |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | A word is offered |
| out_word | output | 16 | Offered header or sample word |

## Verification
A pair stored at edge t reflects the line levels driven before edge t-2. The bench records every level it drives, indexed by edge, and builds the expected pairs from the entry two edges back. The first header word of a period appears in the cycle after the block-start edge that closes it. Each later word appears in the cycle after the edge on which the previous word was accepted. The bench drives inputs at falling edges and reads the outputs there, so each reading falls between the edges it depends on. A word is logged only when valid and ready coincide before an edge. The whole stream of one period is compared after the following period has run long enough to drain it. During each stalled cycle, the bench checks at the next falling edge that the offered word has not changed.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int PERIOD_W = 9;
  localparam logic [2:0] OVS_CHAN_TYPE = 3'd2;

  function automatic logic [15:0] make_hw_id(input logic [4:0] chan);
    return {chan, OVS_CHAN_TYPE, 4'd0, 4'd0};
  endfunction

  function automatic logic [15:0] make_hw_mode(input logic [PERIOD_W-1:0] per);
    return {1'b1, 6'd0, per};
  endfunction

  function automatic logic [15:0] bits_of_pairs(input logic [15:0] pairs);
    return {pairs[14:0], 1'b0};
  endfunction

  function automatic logic [15:0] words_of_bits(input logic [15:0] bits);
    logic [16:0] sum;
    sum = {1'b0, bits} + 17'd15;
    return sum[16:4] > 13'd0 ? {3'd0, sum[16:4]} : 16'd0;
  endfunction
endpackage

// File: rtl/ovs_sync.sv
module ovs_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= async_in[b];
        stage2 <= stage1;
      end
    end
    assign sync_out[b] = stage2;
  end
endmodule

// File: rtl/ovs_sampler.sv
module ovs_sampler
  import ovs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_start,
  input  logic                dclk_en,
  input  logic [PERIOD_W-1:0] cfg_period,
  output logic                armed,
  output logic [PERIOD_W-1:0] period_q,
  output logic                sample_tick
);
  logic [PERIOD_W-1:0] cnt;
  logic                running;

  assign running = armed && (period_q != '0);

  always_comb begin
    if (blk_start) sample_tick = (cfg_period != '0);
    else           sample_tick = running && dclk_en && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      period_q <= '0;
      cnt      <= '0;
    end else if (blk_start) begin
      armed    <= 1'b1;
      period_q <= cfg_period;
      cnt      <= cfg_period - PERIOD_W'(1);
    end else if (running && dclk_en) begin
      cnt <= (cnt == '0) ? period_q - PERIOD_W'(1) : cnt - PERIOD_W'(1);
    end
  end
endmodule

// File: rtl/ovs_framer.sv
module ovs_framer
  import ovs_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int CAP    = WORDS * 8,
  parameter int CNT_W  = $clog2(CAP + 1),
  parameter int BEAT_W = $clog2(WORDS + 3)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_start,
  input  logic                armed,
  input  logic                sample_tick,
  input  logic                smp_data,
  input  logic                smp_clk,
  input  logic [4:0]          cfg_chan,
  input  logic [PERIOD_W-1:0] period_q,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [15:0]         out_word,
  output logic [BEAT_W-1:0]   beat_idx,
  output logic [CNT_W-1:0]    pair_count,
  output logic                emit_start
);
  localparam int WIX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WORDS-1:0][15:0] cap_mem;
  logic [CNT_W-1:0]       pairs;
  logic [4:0]             chan_q;

  logic [WORDS-1:0][15:0] out_mem;
  logic [CNT_W-1:0]       out_pairs;
  logic [15:0]            hw_id_q, hw_mode_q;
  logic                   busy;
  logic [BEAT_W-1:0]      beat;

  logic [CNT_W-1:0] wr_pos;
  logic             wr_en;
  logic [WIX_W-1:0] wr_word;
  logic [3:0]       d_bit, c_bit;
  logic [15:0]      n_data, last_sum;
  logic [BEAT_W-1:0] last_beat;
  logic [15:0]      bit_count;

  assign emit_start = blk_start && armed && !busy;
  assign wr_pos     = blk_start ? '0 : pairs;
  assign wr_en      = sample_tick && (blk_start || (pairs < CNT_W'(CAP)));
  assign wr_word    = WIX_W'(wr_pos >> 3);
  assign d_bit      = 4'd15 - {1'b0, wr_pos[2:0]};
  assign c_bit      = 4'd7 - {1'b0, wr_pos[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_mem <= '0;
      pairs   <= '0;
      chan_q  <= '0;
    end else begin
      if (blk_start) begin
        cap_mem <= '0;
        pairs   <= '0;
        chan_q  <= cfg_chan;
      end
      if (wr_en) begin
        cap_mem[wr_word][d_bit] <= smp_data;
        cap_mem[wr_word][c_bit] <= smp_clk;
        pairs <= wr_pos + CNT_W'(1);
      end
    end
  end

  assign bit_count = bits_of_pairs(16'(out_pairs));
  assign n_data    = words_of_bits(bit_count);
  assign last_sum  = n_data + 16'd2;
  assign last_beat = BEAT_W'(last_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mem   <= '0;
      out_pairs <= '0;
      hw_id_q   <= '0;
      hw_mode_q <= '0;
      busy      <= 1'b0;
      beat      <= '0;
    end else if (emit_start) begin
      out_mem   <= cap_mem;
      out_pairs <= pairs;
      hw_id_q   <= make_hw_id(chan_q);
      hw_mode_q <= make_hw_mode(period_q);
      busy      <= 1'b1;
      beat      <= '0;
    end else if (busy && out_ready) begin
      if (beat == last_beat) busy <= 1'b0;
      else                   beat <= beat + BEAT_W'(1);
    end
  end

  always_comb begin
    case (beat)
      BEAT_W'(0): out_word = hw_id_q;
      BEAT_W'(1): out_word = bit_count;
      BEAT_W'(2): out_word = hw_mode_q;
      default:    out_word = out_mem[WIX_W'(beat - BEAT_W'(3))];
    endcase
  end

  assign out_valid  = busy;
  assign beat_idx   = beat;
  assign pair_count = pairs;
endmodule

// File: rtl/ovs_capture.sv
module ovs_capture
  import ovs_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_start,
  input  logic        dclk_en,
  input  logic        ser_data,
  input  logic        ser_clk,
  input  logic [4:0]  cfg_chan_id,
  input  logic [8:0]  cfg_period,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [15:0] out_word
);
  localparam int CAP    = WORDS * 8;
  localparam int CNT_W  = $clog2(CAP + 1);
  localparam int BEAT_W = $clog2(WORDS + 3);

  logic [1:0]          lines_sync;
  logic                armed;
  logic [PERIOD_W-1:0] period_q;
  logic                sample_tick;
  logic [BEAT_W-1:0]   beat_idx;
  logic [CNT_W-1:0]    pair_count;
  logic                emit_start;

  ovs_sync #(.WIDTH(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_data, ser_clk}),
    .sync_out (lines_sync)
  );

  ovs_sampler u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start   (blk_start),
    .dclk_en     (dclk_en),
    .cfg_period  (cfg_period),
    .armed       (armed),
    .period_q    (period_q),
    .sample_tick (sample_tick)
  );

  ovs_framer #(.WORDS(WORDS)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start   (blk_start),
    .armed       (armed),
    .sample_tick (sample_tick),
    .smp_data    (lines_sync[1]),
    .smp_clk     (lines_sync[0]),
    .cfg_chan    (cfg_chan_id),
    .period_q    (period_q),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_word    (out_word),
    .beat_idx    (beat_idx),
    .pair_count  (pair_count),
    .emit_start  (emit_start)
  );
endmodule

// File: rtl/ovs_capture_chk.sv
module ovs_capture_chk #(
  parameter int CAP    = 32,
  parameter int CNT_W  = 6,
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_start,
  input logic              dclk_en,
  input logic              out_ready,
  input logic              out_valid,
  input logic [15:0]       out_word,
  input logic              armed,
  input logic              sample_tick,
  input logic              emit_start,
  input logic [BEAT_W-1:0] beat_idx,
  input logic [CNT_W-1:0]  pair_count
);
  p_no_early_emit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> armed);

  p_emit_needs_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    emit_start |-> armed);

  p_hw_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat_idx == '0) |-> (out_word[10:0] == 11'h200));

  p_hw_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat_idx == BEAT_W'(2)) |-> (out_word[15:9] == 7'b1000000));

  p_tick_on_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !blk_start) |-> dclk_en);

  p_store_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_count <= CNT_W'(CAP));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_beat_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !emit_start && $past(out_valid)) |=>
      (!out_valid || beat_idx != $past(beat_idx)));
endmodule

bind ovs_capture ovs_capture_chk #(
  .CAP    (CAP),
  .CNT_W  (CNT_W),
  .BEAT_W (BEAT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .blk_start   (blk_start),
  .dclk_en     (dclk_en),
  .out_ready   (out_ready),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .armed       (armed),
  .sample_tick (sample_tick),
  .emit_start  (emit_start),
  .beat_idx    (beat_idx),
  .pair_count  (pair_count)
);

// File: tb/sim_ovs_capture.sv
module sim_ovs_capture;
  localparam int WORDS = 4;
  localparam int CAP   = WORDS * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, blk_start, dclk_en, ser_data, ser_clk, out_ready;
  logic [4:0]  cfg_chan_id;
  logic [8:0]  cfg_period;
  logic        out_valid;
  logic [15:0] out_word;

  ovs_capture #(.WORDS(WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .dclk_en(dclk_en),
    .ser_data(ser_data), .ser_clk(ser_clk), .cfg_chan_id(cfg_chan_id),
    .cfg_period(cfg_period), .out_ready(out_ready), .out_valid(out_valid),
    .out_word(out_word)
  );

  int n_tests = 0, n_fail = 0, idx = 0;
  bit hist_d [0:16383];
  bit hist_c [0:16383];
  bit cur_active = 0;
  int cur_chan, cur_per, cur_div, t0, en_cnt, npairs, rdy_mode;
  bit md [0:255];
  bit mc [0:255];
  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];
  string tag_q[$];
  bit hold_pend = 0;
  logic [15:0] hold_word;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit line_d(int t);
    return 1'(((t * 37) >> 2) ^ (t >> 5));
  endfunction
  function automatic bit line_c(int t);
    return 1'((t >> 1) ^ (t >> 3) ^ (t * 5 >> 4));
  endfunction

  task automatic tick(input bit start);
    bit rdy, smp;
    blk_start = start;
    dclk_en   = cur_active ? ((idx - t0) % cur_div == 0) : 1'b0;
    ser_data  = line_d(idx);
    ser_clk   = line_c(idx);
    hist_d[idx] = ser_data;
    hist_c[idx] = ser_clk;
    rdy = (rdy_mode == 0) ? 1'b1 : ((idx % 3) != 1);
    out_ready = rdy;
    if (hold_pend) begin
      chk(out_valid && out_word == hold_word, "R9 stall hold", out_word, hold_word);
      hold_pend = 0;
    end
    if (out_valid && rdy) got_q.push_back(out_word);
    if (out_valid && !rdy) begin
      hold_pend = 1;
      hold_word = out_word;
    end
    smp = 0;
    if (cur_active && rst_n) begin
      if (start) smp = (cur_per != 0);
      else if (dclk_en) begin
        en_cnt++;
        if (cur_per != 0 && en_cnt % cur_per == 0) smp = 1;
      end
    end
    if (smp && npairs < CAP) begin
      md[npairs] = hist_d[idx - 2];
      mc[npairs] = hist_c[idx - 2];
      npairs++;
    end
    @(posedge clk);
    @(negedge clk);
    idx++;
  endtask

  task automatic build_expected();
    int nw;
    exp_q.delete();
    tag_q.delete();
    exp_q.push_back({5'(cur_chan), 3'd2, 8'd0});
    tag_q.push_back("R2 header id");
    exp_q.push_back(16'(2 * npairs));
    tag_q.push_back(cur_per == 0 ? "R7 zero period count" :
                    (npairs == CAP ? "R8 truncated count" : "R6 bit count"));
    exp_q.push_back({1'b1, 6'd0, 9'(cur_per)});
    tag_q.push_back("R3 R11 header mode");
    nw = (2 * npairs + 15) / 16;
    for (int w = 0; w < nw; w++) begin
      logic [15:0] wv;
      wv = '0;
      for (int s = 0; s < 8; s++) begin
        if (w * 8 + s < npairs) begin
          wv[15 - s] = md[w * 8 + s];
          wv[7 - s]  = mc[w * 8 + s];
        end
      end
      exp_q.push_back(wv);
      tag_q.push_back("R5 R4 R10 sample word");
    end
  endtask

  task automatic run_block(input int chan, input int per, input int div, input int len,
                           input int rmode, input bit scramble);
    bit have_exp;
    have_exp = cur_active;
    if (cur_active) build_expected();
    got_q.delete();
    cur_active = 1; cur_chan = chan; cur_per = per; cur_div = div;
    t0 = idx; en_cnt = 0; npairs = 0; rdy_mode = rmode;
    cfg_chan_id = 5'(chan);
    cfg_period  = 9'(per);
    tick(1);
    for (int i = 1; i < len; i++) begin
      if (scramble && i == len / 2) begin
        cfg_period  = 9'h1AB ^ 9'(per);
        cfg_chan_id = ~5'(chan);
      end
      tick(0);
    end
    if (!have_exp) begin
      chk(got_q.size() == 0, "R1 first start emits nothing", 16'(got_q.size()), 16'd0);
    end else begin
      chk(got_q.size() == exp_q.size(), "R6 word count",
          16'(got_q.size()), 16'(exp_q.size()));
      for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
        chk(got_q[k] === exp_q[k], tag_q[k], got_q[k], exp_q[k]);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pers [6] = '{1, 2, 3, 5, 0, 7};
    int chan;
    rst_n = 0; blk_start = 0; dclk_en = 0; ser_data = 0; ser_clk = 0;
    out_ready = 1; cfg_chan_id = 0; cfg_period = 0; rdy_mode = 0;
    for (int i = 0; i < 4; i++) tick(0);
    rst_n = 1;
    chk(out_valid == 1'b0, "R1 reset valid", 16'(out_valid), 16'd0);
    for (int i = 0; i < 6; i++) tick(0);
    chan = 3;
    for (int d = 1; d <= 3; d++) begin
      for (int p = 0; p < 6; p++) begin
        run_block(chan, pers[p], d, 44, (p + d) % 2, (p % 2) == 1);
        chan = (chan + 7) % 31;
      end
    end
    // header-only block, then exactly one full data word (R5 boundary)
    run_block(30, 0, 1, 30, 0, 0);
    run_block(17, 1, 1, 8, 0, 0);
    // heavy truncation (R8), then stalled drain
    run_block(0, 1, 1, 70, 1, 1);
    run_block(31, 4, 2, 40, 1, 0);
    run_block(9, 0, 1, 30, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule